// File: doc/BRIEF.md
# Multi-Queue FIFO with Pipelined Read Port

The block keeps four independent FIFO queues in one shared storage array, all in one clock domain. The write side picks a target queue with a select strobe and a queue number, then pushes 18-bit words into it. The read side picks its source queue the same way: an enable strobe qualifies a queue-number bus. A pop request (active low) then pulls the head word of that queue through a two-stage output pipeline. An active-low output-valid flag travels with each word, so the flag describes the word on the bus. When a read finds its queue empty, the flag goes high.

At master reset the read port samples a width strap. With the strap high, each stored word leaves as two 9-bit halves, lower half first, and the word is popped only after its upper half has gone out. A per-queue partial reset returns one queue's pointers to the start. It is accepted only if the same queue has been selected on both sides for at least two cycles. A read selection is refused until a configuration-done input is high. A read selection that coincides with the flag strobe is rejected and flagged as an error.

Top module: `mq_fifo_rdport`

## Requirements
- R1: During and right after master reset (`rst_n` low at a clock edge), `out_valid_n` is 1, `rd_data` is 0, `sel_err` is 0 and every queue is empty.
- R2: A read selection takes effect at a clock edge where `rsel_en` is 1, `flag_strobe` is 0 and `cfg_done` is 1. While `cfg_done` is 0 it is ignored, and with no read queue selected a pop request changes nothing.
- R3: A pop request (`rd_en_n` 0) on a selected non-empty queue puts the head word on `rd_data` with `out_valid_n` 0 at the second rising edge after the request cycle. Each queue delivers its words in write order.
- R4: The four queues are independent. After a read selection, the next pop request returns data from the newly selected queue two edges later.
- R5: A pop request on an empty selected queue drives `out_valid_n` to 1 at the second edge after the request.
- R6: If `rsel_en` and `flag_strobe` are both 1 in a cycle, `sel_err` is 1 during the following cycle only, and the read selection keeps its old queue.
- R7: An accepted partial reset (`part_rst_n` 0 for one cycle) empties only the commonly selected queue and restarts its pointers. Other queues keep their contents.
- R8: A partial reset is ignored unless the write and read selections name the same queue and the later of the two selections was made at least two cycles before the reset cycle.
- R9: With `half_width_cfg` 1 at master reset, each word leaves as two reads. The first read gives bits 8:0 and the second gives bits 17:9, each on `rd_data[8:0]` with `rd_data[17:9]` zero. The word is popped after the second read.
- R10: A queue holds 16 words. A push into a full queue is dropped.
- R11: While `rd_en_n` is 1, `rd_data` and `out_valid_n` hold their values and no word is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Synchronous active-low master reset |
| half_width_cfg | input | 1 | Width strap sampled during reset: 0 = 18-bit, 1 = 9-bit |
| cfg_done | input | 1 | Configuration finished; read selections are allowed only when high |
| wsel_en | input | 1 | Write-queue selection strobe |
| wsel_q | input | 2 | Write-queue number |
| wr_en | input | 1 | Push request into the selected write queue |
| wr_data | input | 18 | Word to push |
| rsel_en | input | 1 | Read-queue selection strobe |
| rsel_q | input | 2 | Read-queue number |
| flag_strobe | input | 1 | Flag strobe; must not coincide with rsel_en |
| rd_en_n | input | 1 | Active-low pop request |
| part_rst_n | input | 1 | Active-low one-cycle partial reset request |
| rd_data | output | 18 | Output word (or 9-bit half, zero-extended) |
| out_valid_n | output | 1 | Active-low valid flag for rd_data |
| sel_err | output | 1 | One-cycle pulse after a select/strobe collision |

## Verification
Every pop request lands on `rd_data` and `out_valid_n` at the second rising edge after its request cycle. The bench therefore drives each request from a falling edge, lets two rising edges pass and samples at the falling edge that follows. `sel_err` is due one edge after the collision cycle and is sampled on the next falling edge, and again one cycle later to confirm it clears. Selections and partial resets count their lead time in edges from the selecting edge. A partial reset is always followed by a read of the same queue, so its effect shows up at the output port.

// File: rtl/mqf_pkg.sv
// Package: shared types of the multi-queue FIFO read port.
// Assumes: nothing beyond standard SystemVerilog.
package mqf_pkg;
    // Output width mode latched at master reset
    typedef enum logic {
        WIDTH_FULL = 1'b0,
        WIDTH_HALF = 1'b1
    } width_mode_e;
endpackage

// File: rtl/mqf_sel_ctrl.sv
// Module: queue selection control.
// Holds the write and read queue selections, refuses read selections before
// configuration is done or when they collide with the flag strobe, and
// decides whether a partial reset request is accepted.
// Assumes: all inputs synchronous to clk; rst_n is synchronous active low.
module mqf_sel_ctrl #(
    parameter int NQ = 4,
    parameter int QW = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_done,
    input  logic          wsel_en,
    input  logic [QW-1:0] wsel_q,
    input  logic          rsel_en,
    input  logic [QW-1:0] rsel_q,
    input  logic          flag_strobe,
    input  logic          part_rst_n,
    output logic [QW-1:0] wq_sel,
    output logic          wq_vld,
    output logic [QW-1:0] rq_sel,
    output logic          rq_vld,
    output logic          rsel_evt,
    output logic          sel_err,
    output logic          prs_go,
    output logic [QW-1:0] prs_q
);
    logic       any_sel;
    logic [1:0] age;

    assign rsel_evt = rsel_en && !flag_strobe && cfg_done;
    assign any_sel  = rsel_evt || wsel_en;

    // Write-side selection register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wq_sel <= '0;
            wq_vld <= 1'b0;
        end else if (wsel_en) begin
            wq_sel <= wsel_q;
            wq_vld <= 1'b1;
        end
    end

    // Read-side selection register, gated by configuration and collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_sel <= '0;
            rq_vld <= 1'b0;
        end else if (rsel_evt) begin
            rq_sel <= rsel_q;
            rq_vld <= 1'b1;
        end
    end

    // Collision error pulse, one cycle after the offending cycle
    always_ff @(posedge clk) begin
        if (!rst_n) sel_err <= 1'b0;
        else        sel_err <= rsel_en && flag_strobe;
    end

    // Cycles elapsed since the most recent selection of either side
    always_ff @(posedge clk) begin
        if (!rst_n)            age <= '0;
        else if (any_sel)      age <= 2'd1;
        else if (age != 2'd3)  age <= age + 2'd1;
    end

    assign prs_go = !part_rst_n && wq_vld && rq_vld && (wq_sel == rq_sel)
                    && (age >= 2'd2) && !any_sel;
    assign prs_q  = rq_sel;
endmodule

// File: rtl/mqf_queue_ctrl.sv
// Module: per-queue pointer and occupancy bookkeeping.
// One read pointer, write pointer and count per queue; a partial reset of a
// queue overrides any push or pop to it in the same cycle.
// Assumes: DEPTH is a power of two so pointers wrap naturally.
module mqf_queue_ctrl #(
    parameter int NQ    = 4,
    parameter int DEPTH = 16,
    parameter int QW    = $clog2(NQ),
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [QW-1:0]  push_q,
    input  logic           pop,
    input  logic [QW-1:0]  pop_q,
    input  logic           prs_go,
    input  logic [QW-1:0]  prs_q,
    output logic           push_acc,
    output logic [PW-1:0]  wr_ptr,
    output logic [PW-1:0]  rd_ptr,
    output logic           rd_empty,
    output logic [NQ*CW-1:0] cnt_flat
);
    logic [NQ*PW-1:0] rp_flat;
    logic [NQ*PW-1:0] wp_flat;
    logic [NQ-1:0]    push_vec;

    for (genvar i = 0; i < NQ; i++) begin : g_q
        logic [PW-1:0] rp;
        logic [PW-1:0] wp;
        logic [CW-1:0] cnt;
        logic          hit_prs;
        logic          do_push;
        logic          do_pop;

        assign hit_prs = prs_go && (prs_q == QW'(i));
        assign do_push = push && (push_q == QW'(i)) && (cnt != CW'(DEPTH)) && !hit_prs;
        assign do_pop  = pop && (pop_q == QW'(i)) && (cnt != '0) && !hit_prs;

        // Pointer and count update for queue i
        always_ff @(posedge clk) begin
            if (!rst_n || hit_prs) begin
                rp  <= '0;
                wp  <= '0;
                cnt <= '0;
            end else begin
                if (do_push) wp <= wp + 1'b1;
                if (do_pop)  rp <= rp + 1'b1;
                case ({do_push, do_pop})
                    2'b10:   cnt <= cnt + 1'b1;
                    2'b01:   cnt <= cnt - 1'b1;
                    default: cnt <= cnt;
                endcase
            end
        end

        assign rp_flat[i*PW +: PW]  = rp;
        assign wp_flat[i*PW +: PW]  = wp;
        assign cnt_flat[i*CW +: CW] = cnt;
        assign push_vec[i]          = do_push;
    end

    assign push_acc = |push_vec;
    assign wr_ptr   = wp_flat[push_q*PW +: PW];
    assign rd_ptr   = rp_flat[pop_q*PW +: PW];
    assign rd_empty = (cnt_flat[pop_q*CW +: CW] == '0);
endmodule

// File: rtl/mqf_rd_pipe.sv
// Module: two-stage read output pipeline with optional half-width output.
// Stage 1 captures the fetched word (or half) and its validity; stage 2
// drives the port. In half mode a phase bit walks low half then high half
// and the word is popped only with the high half.
// Assumes: DW is even; the caller only asserts rd_ok for a non-empty queue.
module mqf_rd_pipe #(
    parameter int DW = 18,
    parameter int HW = DW / 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  mqf_pkg::width_mode_e mode,
    input  logic                rd_req,
    input  logic                rd_ok,
    input  logic                phase_clr,
    input  logic [DW-1:0]       word,
    output logic                pop,
    output logic [DW-1:0]       rd_data,
    output logic                out_valid_n
);
    logic          phase;
    logic          s1_upd;
    logic          s1_vld;
    logic [DW-1:0] s1_data;
    logic [DW-1:0] pick;

    assign pop = rd_ok && ((mode == mqf_pkg::WIDTH_FULL) || phase);

    // Choose the full word or the current half, zero-extended
    always_comb begin
        if (mode == mqf_pkg::WIDTH_FULL) pick = word;
        else if (phase)                  pick = {{HW{1'b0}}, word[DW-1:HW]};
        else                             pick = {{(DW-HW){1'b0}}, word[HW-1:0]};
    end

    // Half-select phase; restarts on a new read queue or its partial reset
    always_ff @(posedge clk) begin
        if (!rst_n || phase_clr)                       phase <= 1'b0;
        else if (rd_ok && mode == mqf_pkg::WIDTH_HALF) phase <= !phase;
    end

    // Stage 1: capture fetch result for every pop request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_upd  <= 1'b0;
            s1_vld  <= 1'b0;
            s1_data <= '0;
        end else begin
            s1_upd  <= rd_req;
            s1_vld  <= rd_ok;
            s1_data <= rd_ok ? pick : '0;
        end
    end

    // Stage 2: output register, updated only behind a pop request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data     <= '0;
            out_valid_n <= 1'b1;
        end else if (s1_upd) begin
            rd_data     <= s1_data;
            out_valid_n <= !s1_vld;
        end
    end
endmodule

// File: rtl/mq_fifo_rdport.sv
// Module: multi-queue FIFO with pipelined, selectable read port (top).
// NQ queues of DEPTH words share one storage array, each in its own region
// addressed by {queue, pointer}. Write and read sides each select a queue;
// pops come out two edges after the request with an active-low valid flag.
// Assumes: single clock; synchronous active-low master reset; DEPTH and NQ
// powers of two; DW even.
module mq_fifo_rdport #(
    parameter int NQ    = 4,
    parameter int DW    = 18,
    parameter int DEPTH = 16,
    parameter int QW    = $clog2(NQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_width_cfg,
    input  logic          cfg_done,
    input  logic          wsel_en,
    input  logic [QW-1:0] wsel_q,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rsel_en,
    input  logic [QW-1:0] rsel_q,
    input  logic          flag_strobe,
    input  logic          rd_en_n,
    input  logic          part_rst_n,
    output logic [DW-1:0] rd_data,
    output logic          out_valid_n,
    output logic          sel_err
);
    localparam int PW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int WORDS = NQ * DEPTH;

    mqf_pkg::width_mode_e mode;
    logic [QW-1:0]  wq_sel;
    logic           wq_vld;
    logic [QW-1:0]  rq_sel;
    logic           rq_vld;
    logic           rsel_evt;
    logic           prs_go;
    logic [QW-1:0]  prs_q;
    logic           push_acc;
    logic [PW-1:0]  wr_ptr;
    logic [PW-1:0]  rd_ptr;
    logic           rd_empty;
    logic [NQ*CW-1:0] cnt_flat;
    logic           rd_req;
    logic           rd_ok;
    logic           prs_on_rd;
    logic           pop;
    logic [DW-1:0]  word;
    logic [DW-1:0]  mem [WORDS];

    // Width strap latched while master reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= mqf_pkg::width_mode_e'(half_width_cfg);
    end

    mqf_sel_ctrl #(.NQ(NQ), .QW(QW)) u_sel (
        .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done),
        .wsel_en(wsel_en), .wsel_q(wsel_q),
        .rsel_en(rsel_en), .rsel_q(rsel_q), .flag_strobe(flag_strobe),
        .part_rst_n(part_rst_n),
        .wq_sel(wq_sel), .wq_vld(wq_vld), .rq_sel(rq_sel), .rq_vld(rq_vld),
        .rsel_evt(rsel_evt), .sel_err(sel_err), .prs_go(prs_go), .prs_q(prs_q)
    );

    mqf_queue_ctrl #(.NQ(NQ), .DEPTH(DEPTH), .QW(QW), .PW(PW), .CW(CW)) u_qc (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en && wq_vld), .push_q(wq_sel),
        .pop(pop), .pop_q(rq_sel),
        .prs_go(prs_go), .prs_q(prs_q),
        .push_acc(push_acc), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .rd_empty(rd_empty), .cnt_flat(cnt_flat)
    );

    assign rd_req    = !rd_en_n && rq_vld;
    assign prs_on_rd = prs_go && (prs_q == rq_sel);
    assign rd_ok     = rd_req && !rd_empty && !prs_on_rd;

    // Shared storage write port
    always_ff @(posedge clk) begin
        if (push_acc) mem[{wq_sel, wr_ptr}] <= wr_data;
    end

    assign word = mem[{rq_sel, rd_ptr}];

    mqf_rd_pipe #(.DW(DW)) u_rp (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .rd_req(rd_req), .rd_ok(rd_ok), .phase_clr(rsel_evt || prs_on_rd),
        .word(word), .pop(pop),
        .rd_data(rd_data), .out_valid_n(out_valid_n)
    );
endmodule

// File: rtl/mqf_checker.sv
// Module: assertion checker bound to mq_fifo_rdport.
// Assumes: signals sampled at the rising edge; rst_n synchronous active low.
module mqf_checker #(
    parameter int NQ    = 4,
    parameter int DW    = 18,
    parameter int DEPTH = 16,
    parameter int QW    = $clog2(NQ),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_done,
    input logic             rsel_en,
    input logic             flag_strobe,
    input logic [QW-1:0]    rq_sel,
    input logic             rd_req,
    input logic             prs_go,
    input logic [QW-1:0]    prs_q,
    input logic [NQ*CW-1:0] cnt_flat,
    input logic [DW-1:0]    rd_data,
    input logic             out_valid_n,
    input logic             sel_err
);
    // R1: outputs idle right after a reset edge
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (out_valid_n && rd_data == '0 && !sel_err));

    // R6: collision raises the error flag in the next cycle
    a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel_en && flag_strobe) |=> sel_err);

    // R6: no collision, no error flag
    a_r6_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsel_en && flag_strobe) |=> !sel_err);

    // R6: collided selection leaves the read queue unchanged
    a_r6_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel_en && flag_strobe) |=> $stable(rq_sel));

    // R2: no read selection change before configuration is done
    a_r2_no_sel_early: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> $stable(rq_sel));

    // R3: a valid word only appears behind a pop request two edges earlier
    a_r3_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid_n) |-> $past(rd_req, 2));

    for (genvar i = 0; i < NQ; i++) begin : g_chk
        // R10: occupancy never exceeds the queue depth
        a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_flat[i*CW +: CW] <= CW'(DEPTH));
        // R7: accepted partial reset empties its queue
        a_r7_prs_empties: assert property (@(posedge clk) disable iff (!rst_n)
            (prs_go && prs_q == QW'(i)) |=> (cnt_flat[i*CW +: CW] == '0));
    end
endmodule

bind mq_fifo_rdport mqf_checker #(.NQ(NQ), .DW(DW), .DEPTH(DEPTH), .QW(QW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .rsel_en(rsel_en),
    .flag_strobe(flag_strobe), .rq_sel(rq_sel), .rd_req(rd_req),
    .prs_go(prs_go), .prs_q(prs_q), .cnt_flat(cnt_flat),
    .rd_data(rd_data), .out_valid_n(out_valid_n), .sel_err(sel_err)
);

// File: tb/sim_mq_fifo_rdport.sv
`timescale 1ns/1ps
module sim_mq_fifo_rdport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_width_cfg = 1'b0;
    logic        cfg_done = 1'b0;
    logic        wsel_en = 1'b0;
    logic [1:0]  wsel_q = '0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic        rsel_en = 1'b0;
    logic [1:0]  rsel_q = '0;
    logic        flag_strobe = 1'b0;
    logic        rd_en_n = 1'b1;
    logic        part_rst_n = 1'b1;
    logic [17:0] rd_data;
    logic        out_valid_n;
    logic        sel_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    mq_fifo_rdport u0 (.*);

    always #2 clk = ~clk;

    // Table of writes: {queue, word}
    localparam logic [19:0] VEC [8] = '{
        {2'd0, 18'h00A11}, {2'd1, 18'h01B22}, {2'd2, 18'h02C33}, {2'd0, 18'h3FFFF},
        {2'd3, 18'h20044}, {2'd1, 18'h15555}, {2'd2, 18'h2AAAA}, {2'd0, 18'h00000}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 50000", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wsel(input logic [1:0] q);
        wsel_en = 1'b1; wsel_q = q; tick(); wsel_en = 1'b0;
    endtask

    task automatic rsel(input logic [1:0] q);
        rsel_en = 1'b1; rsel_q = q; tick(); rsel_en = 1'b0;
    endtask

    task automatic wr(input logic [17:0] d);
        wr_en = 1'b1; wr_data = d; tick(); wr_en = 1'b0;
    endtask

    task automatic prs();
        part_rst_n = 1'b0; tick(); part_rst_n = 1'b1;
    endtask

    // Pop request in one cycle, result sampled after the second edge
    task automatic rd_chk(input string tag, input logic exp_vn, input logic [17:0] exp_d);
        rd_en_n = 1'b0; tick(); rd_en_n = 1'b1; tick();
        chk({tag, " valid_n"}, 18'(out_valid_n), 18'(exp_vn));
        if (!exp_vn) chk({tag, " data"}, rd_data, exp_d);
    endtask

    task automatic do_reset(input logic half);
        rst_n = 1'b0; half_width_cfg = half;
        tick(); tick();
        chk("R1 reset valid_n", 18'(out_valid_n), 18'd1);
        chk("R1 reset data", rd_data, 18'd0);
        chk("R1 reset sel_err", 18'(sel_err), 18'd0);
        rst_n = 1'b1; half_width_cfg = 1'b0;
        tick();
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b0);

        // Table walk: load every queue
        for (int i = 0; i < 8; i++) begin
            wsel(VEC[i][19:18]);
            wr(VEC[i][17:0]);
        end

        // R2: read selection refused before cfg_done
        rsel(2'd1);
        rd_chk("R2 select before cfg_done", 1'b1, 18'd0);
        cfg_done = 1'b1;

        // R3/R4/R5: drain each queue in table order, then read empty
        for (int q = 0; q < 4; q++) begin
            int n = 0;
            rsel(2'(q));
            for (int i = 0; i < 8; i++) begin
                if (VEC[i][19:18] == 2'(q)) begin
                    rd_chk("R3 R4 fifo order", 1'b0, VEC[i][17:0]);
                    if (q == 0 && n == 0) begin
                        // R11: no pop request, output holds
                        tick(); tick(); tick();
                        chk("R11 hold data", rd_data, VEC[i][17:0]);
                        chk("R11 hold valid_n", 18'(out_valid_n), 18'd0);
                    end
                    n++;
                end
            end
            rd_chk("R5 empty queue", 1'b1, 18'd0);
        end

        // R6: collision raises sel_err, selection kept
        wsel(2'd2); wr(18'h12345);
        wsel(2'd0); wr(18'h0ABCD);
        rsel(2'd0);
        rsel_en = 1'b1; flag_strobe = 1'b1; rsel_q = 2'd2; tick();
        rsel_en = 1'b0; flag_strobe = 1'b0;
        chk("R6 sel_err pulse", 18'(sel_err), 18'd1);
        tick();
        chk("R6 sel_err clears", 18'(sel_err), 18'd0);
        rd_chk("R6 selection kept", 1'b0, 18'h0ABCD);

        // R8: partial reset too soon after selection is ignored
        wsel(2'd0); wr(18'h00777);
        rsel(2'd0);
        prs();
        rd_chk("R8 early partial reset ignored", 1'b0, 18'h00777);

        // R8: partial reset with differing queues is ignored
        wsel(2'd0); wr(18'h00999);
        wsel(2'd1); wr(18'h00888);
        tick(); tick(); tick();
        prs();
        rd_chk("R8 mismatched partial reset ignored", 1'b0, 18'h00999);

        // R7: accepted partial reset empties only queue 1
        rsel(2'd1);
        tick(); tick();
        prs();
        rd_chk("R7 queue emptied", 1'b1, 18'd0);
        rsel(2'd2);
        rd_chk("R7 other queue kept", 1'b0, 18'h12345);
        wsel(2'd1); wr(18'h00321);
        rsel(2'd1);
        rd_chk("R7 pointers restart", 1'b0, 18'h00321);

        // R10: 17 pushes, only 16 kept
        wsel(2'd3);
        for (int i = 0; i < 17; i++) wr(18'h100 + 18'(i));
        rsel(2'd3);
        for (int i = 0; i < 16; i++) rd_chk("R10 full queue data", 1'b0, 18'h100 + 18'(i));
        rd_chk("R10 overflow dropped", 1'b1, 18'd0);

        // R9: half-width mode
        do_reset(1'b1);
        wsel(2'd0); wr(18'h3F00A); wr(18'h1C0DE);
        rsel(2'd0);
        rd_chk("R9 low half", 1'b0, {9'd0, 9'(18'h3F00A)});
        rd_chk("R9 high half", 1'b0, {9'd0, 9'(18'h3F00A >> 9)});
        rd_chk("R9 next low half", 1'b0, {9'd0, 9'(18'h1C0DE)});
        rd_chk("R9 next high half", 1'b0, {9'd0, 9'(18'h1C0DE >> 9)});
        rd_chk("R9 popped after two halves", 1'b1, 18'd0);

        summary();
        $finish;
    end
endmodule